// File: doc/BRIEF.md
# Twelve-Pin General-Purpose I/O Controller

This block controls twelve general-purpose pins through a small word-addressed register interface. Each pin can be used as an input, as a push-pull output or as an open-drain output. Each pin can also raise a level-sensitive interrupt, and software picks the active level separately for every pin. All pad inputs pass through a two-flop synchroniser before the controller reads them back or tests them for interrupts. The block drives the pad with a value and an output enable, and the pad cell forms the tri-state buffer from these two signals.

Two pins, 9 and 8, can also be driven by an outside timestamp-compare unit. That unit supplies an output enable and a value for each of the two pins. Pins 7 to 0 can be given to an LED driver. Eight strap inputs, captured while reset is held, set which of these pins start in LED mode, and software can change that choice afterwards. A pin in LED mode drives the LED value supplied from outside and raises no GPIO interrupt.

Top module: `pin_io_ctrl`

## Requirements
- R1: Every pin is set up on its own. When a pin's direction bit is 1, a read of the data register (word 0) returns the value written for that pin. When the bit is 0, the read returns the synchronised pad level. Both kinds of pin can share one read.
- R2: While reset is held, every direction bit (word 1) is cleared. Every pin that is not in LED mode then has its output enable low.
- R3: While reset is held, the interrupt enable bits (word 4) and the polarity bits (word 3) are all cleared. A polarity bit of 0 means the pin is active when it is low.
- R4: A pin with direction 1 and open-drain bit 0 (word 2) is push-pull. Its output enable is 1 and its pad value equals its data bit.
- R5: A pin with direction 1 and open-drain bit 1 drives low (enable 1, value 0) when its data bit is 0. It releases the pad (enable 0) when its data bit is 1.
- R6: A change on a pad input shows up in the data-register read on the second rising clock edge after it, and not earlier.
- R7: Bit 0 of the timestamp inputs belongs to pin 8 and bit 1 belongs to pin 9. A pin is an output when its direction bit or its timestamp enable is set. While the timestamp enable is set, the pin sends the timestamp value in place of its data bit. The open-drain bit applies to that value as well.
- R8: The LED select register (word 6, bits 7:0) takes the strap inputs while reset is held and can be written after reset. A pin with its LED select bit at 1 has its output enable at 1 and drives its bit of the LED value.
- R9: A status bit (word 5) becomes 1 when the pin's interrupt enable is 1 and the synchronised level equals its polarity bit (1 means active high). A pin whose enable is 0 does not set its status bit.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If the pin is still enabled and at its active level, the bit is set again in the same cycle.
- R11: The interrupt output is high exactly when some status bit is 1 and its enable is 1. A status bit stays set after its enable is removed.
- R12: A pin in LED mode sets no status bit and does not raise the interrupt output.
- R13: Words 0 to 6 are data, direction, open-drain, polarity, interrupt enable, status and LED select. Reading word 7 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for the register interface |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 12 | Pad levels, not synchronised |
| pad_out | output | 12 | Value sent to each pad |
| pad_oe | output | 12 | Output enable for each pad |
| ts_oe | input | 2 | Timestamp output enable for pins 9:8 |
| ts_val | input | 2 | Timestamp output value for pins 9:8 |
| led_val | input | 8 | LED drive value for pins 7:0 |
| strap_led | input | 8 | LED select straps, captured while reset is held |
| irq | output | 1 | Interrupt output |

## Verification
The assertions assume two things. First, the strap inputs are stable while reset is held. Second, the register interface is only written with a defined word index. The stimulus changes bus, pad, timestamp and strap inputs only on falling clock edges. It holds each pad level for at least four cycles before it checks a status bit or a read, so every change has passed both synchroniser stages before it is judged. The interrupt tests clear old status first, or account for status bits that are still set.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int NPIN    = 12;
    localparam int NLED    = 8;
    localparam int TS_LO   = 8;
    localparam int NTS     = 2;
    localparam int AW      = 3;
    localparam int DW      = 32;
    localparam int SYNC_ST = 2;

    typedef enum logic [AW-1:0] {
        W_LEVEL  = 3'd0,
        W_DIR    = 3'd1,
        W_ODRAIN = 3'd2,
        W_POL    = 3'd3,
        W_IEN    = 3'd4,
        W_ISTAT  = 3'd5,
        W_LEDSEL = 3'd6
    } word_e;

    typedef struct packed {
        logic [NPIN-1:0] lvl;
        logic [NPIN-1:0] dir;
        logic [NPIN-1:0] od;
        logic [NPIN-1:0] pol;
        logic [NPIN-1:0] ien;
        logic [NLED-1:0] led;
    } pin_cfg_t;

    function automatic logic [DW-1:0] widen(input logic [NPIN-1:0] v);
        return {{(DW-NPIN){1'b0}}, v};
    endfunction

    function automatic logic [NPIN-1:0] led_mask(input logic [NLED-1:0] v);
        return {{(NPIN-NLED){1'b0}}, v};
    endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int WIDTH  = 12,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) st[k] <= '0;
        end else begin
            st[0] <= d;
            for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    input  logic [NPIN-1:0]      pin_lvl,
    input  logic [NLED-1:0]      strap,
    output pin_cfg_t             cfg,
    output logic                 irq
);
    logic [NPIN-1:0] stat;
    logic [NPIN-1:0] clr;
    logic [NPIN-1:0] hit;
    logic [NPIN-1:0] gpio_only;
    logic [NPIN-1:0] wv;

    assign wv        = wdata[NPIN-1:0];
    assign gpio_only = ~led_mask(cfg.led);
    assign hit       = ~(pin_lvl ^ cfg.pol) & cfg.ien & gpio_only;
    assign clr       = (wr && word_e'(addr) == W_ISTAT) ? wv : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.lvl <= '0;
            cfg.dir <= '0;
            cfg.od  <= '0;
            cfg.pol <= '0;
            cfg.ien <= '0;
            cfg.led <= strap;
            stat    <= '0;
        end else begin
            if (wr) begin
                case (word_e'(addr))
                    W_LEVEL:  cfg.lvl <= wv;
                    W_DIR:    cfg.dir <= wv;
                    W_ODRAIN: cfg.od  <= wv;
                    W_POL:    cfg.pol <= wv;
                    W_IEN:    cfg.ien <= wv;
                    W_LEDSEL: cfg.led <= wdata[NLED-1:0];
                    default:  ;
                endcase
            end
            stat <= (stat & ~clr) | hit;
        end
    end

    always_comb begin
        case (word_e'(addr))
            W_LEVEL:  rdata = widen((cfg.lvl & cfg.dir) | (pin_lvl & ~cfg.dir));
            W_DIR:    rdata = widen(cfg.dir);
            W_ODRAIN: rdata = widen(cfg.od);
            W_POL:    rdata = widen(cfg.pol);
            W_IEN:    rdata = widen(cfg.ien);
            W_ISTAT:  rdata = widen(stat);
            W_LEDSEL: rdata = {{(DW-NLED){1'b0}}, cfg.led};
            default:  rdata = '0;
        endcase
    end

    assign irq = |(stat & cfg.ien & gpio_only);

    // R2 / R3: configuration comes out of reset cleared
    p_reset_clear_r2: assert property (@(posedge clk)
        rst |=> (cfg.dir == '0 && cfg.ien == '0 && cfg.pol == '0 && stat == '0));

    // R8: LED select follows the straps held during reset
    p_strap_capture_r8: assert property (@(posedge clk)
        rst |=> (cfg.led == $past(strap)));

    // R9 / R12: a newly set status bit needs an enabled GPIO pin at its active level
    p_stat_cause_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((stat & ~$past(stat) &
            ~($past(cfg.ien) & ~($past(pin_lvl) ^ $past(cfg.pol)) &
              ~led_mask($past(cfg.led)))) == '0));

    // R10: a status bit only drops after a write of 1 to it
    p_stat_clear_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((~stat & $past(stat) & ~$past(clr)) == '0));
endmodule

// File: rtl/pio_padmux.sv
module pio_padmux #(
    parameter int N_PIN = 12,
    parameter int N_LED = 8,
    parameter int TS_LO = 8,
    parameter int N_TS  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_PIN-1:0] lvl,
    input  logic [N_PIN-1:0] dir,
    input  logic [N_PIN-1:0] od,
    input  logic [N_LED-1:0] led_sel,
    input  logic [N_LED-1:0] led_val,
    input  logic [N_TS-1:0]  ts_oe,
    input  logic [N_TS-1:0]  ts_val,
    output logic [N_PIN-1:0] out,
    output logic [N_PIN-1:0] oe
);
    for (genvar g = 0; g < N_PIN; g++) begin : g_pin
        logic drv, val, led_on, led_v, ts_req;

        if (g >= TS_LO && g < TS_LO + N_TS) begin : g_ts
            assign ts_req = ts_oe[g-TS_LO];
            assign val    = ts_oe[g-TS_LO] ? ts_val[g-TS_LO] : lvl[g];
        end else begin : g_plain
            assign ts_req = 1'b0;
            assign val    = lvl[g];
        end

        if (g < N_LED) begin : g_led
            assign led_on = led_sel[g];
            assign led_v  = led_val[g];
        end else begin : g_noled
            assign led_on = 1'b0;
            assign led_v  = 1'b0;
        end

        assign drv    = dir[g] | ts_req;
        assign out[g] = led_on ? led_v : (drv & ~od[g] & val);
        assign oe[g]  = led_on | (drv & (~od[g] | ~val));

        // R2: a GPIO pin with no output request leaves its pad undriven
        p_input_hiz_r2: assert property (@(posedge clk) disable iff (rst)
            (!led_on && !dir[g] && !ts_req) |-> !oe[g]);

        // R5: an open-drain pin never drives a high level
        p_od_no_high_r5: assert property (@(posedge clk) disable iff (rst)
            (!led_on && od[g]) |-> !(oe[g] && out[g]));
    end
endmodule

// File: rtl/pin_io_ctrl.sv
module pin_io_ctrl
    import pio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [AW-1:0]        bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    input  logic [NPIN-1:0]      pad_in,
    output logic [NPIN-1:0]      pad_out,
    output logic [NPIN-1:0]      pad_oe,
    input  logic [NTS-1:0]       ts_oe,
    input  logic [NTS-1:0]       ts_val,
    input  logic [NLED-1:0]      led_val,
    input  logic [NLED-1:0]      strap_led,
    output logic                 irq
);
    logic [NPIN-1:0] pin_sync;
    pin_cfg_t        cfg;

    pio_sync #(.WIDTH(NPIN), .STAGES(SYNC_ST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_sync)
    );

    pio_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .pin_lvl (pin_sync),
        .strap   (strap_led),
        .cfg     (cfg),
        .irq     (irq)
    );

    pio_padmux #(.N_PIN(NPIN), .N_LED(NLED), .TS_LO(TS_LO), .N_TS(NTS)) u_pad (
        .clk     (clk),
        .rst     (rst),
        .lvl     (cfg.lvl),
        .dir     (cfg.dir),
        .od      (cfg.od),
        .led_sel (cfg.led),
        .led_val (led_val),
        .ts_oe   (ts_oe),
        .ts_val  (ts_val),
        .out     (pad_out),
        .oe      (pad_oe)
    );

    // R12: a raised interrupt always has a non-LED pin behind it
    p_irq_source_r12: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((cfg.ien & ~led_mask(cfg.led)) != '0));
endmodule

// File: tb/pin_io_ctrl_test.sv
module pin_io_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [11:0] pad_in = '0;
    logic [11:0] pad_out, pad_oe;
    logic [1:0]  ts_oe = '0, ts_val = '0;
    logic [7:0]  led_val = '0;
    logic [7:0]  strap_led = 8'hA5;
    logic        irq;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_io_ctrl uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd1, v); chk("R2 dir cleared", v, 32'h0);
        chk("R2 non-LED pins undriven", {20'h0, pad_oe}, 32'h0A5);
        rd(3'd3, v); chk("R3 polarity cleared", v, 32'h0);
        rd(3'd4, v); chk("R3 enables cleared", v, 32'h0);
        rd(3'd6, v); chk("R8 straps captured", v, 32'hA5);
        rd(3'd7, v); chk("R13 unmapped word reads zero", v, 32'h0);
        wr(3'd6, 32'h0);
    endtask

    task automatic t_pushpull();
        logic [31:0] v;
        wr(3'd2, 32'h0); wr(3'd0, 32'hA5C); wr(3'd1, 32'hFFF);
        chk("R4 push-pull oe", {20'h0, pad_oe}, 32'hFFF);
        chk("R4 push-pull out", {20'h0, pad_out}, 32'hA5C);
        rd(3'd0, v); chk("R1 output readback", v, 32'hA5C);
    endtask

    task automatic t_opendrain();
        wr(3'd2, 32'hFFF); wr(3'd0, 32'h0F0);
        chk("R5 open-drain oe", {20'h0, pad_oe}, 32'hF0F);
        chk("R5 open-drain out", {20'h0, pad_out}, 32'h0);
        wr(3'd2, 32'h0);
    endtask

    task automatic t_input();
        logic [31:0] v;
        wr(3'd1, 32'h0);
        settle();
        @(negedge clk); pad_in = 12'h3C5;
        @(negedge clk); rd(3'd0, v); chk("R6 not visible after one edge", v, 32'h0);
        @(negedge clk); rd(3'd0, v); chk("R6 visible after two edges", v, 32'h3C5);
        chk("R2 input pins undriven", {20'h0, pad_oe}, 32'h0);
        wr(3'd0, 32'h00A); wr(3'd1, 32'h00F);
        rd(3'd0, v); chk("R1 mixed readback", v, 32'h3CA);
        wr(3'd1, 32'h0); wr(3'd0, 32'h0);
    endtask

    task automatic t_ts();
        @(negedge clk); ts_oe = 2'b10; ts_val = 2'b10; #1;
        chk("R7 pin9 driven by timestamp", {30'h0, pad_oe[9:8]}, 32'h2);
        chk("R7 pin9 timestamp value", {30'h0, pad_out[9:8]}, 32'h2);
        @(negedge clk); ts_oe = 2'b11; ts_val = 2'b01; #1;
        chk("R7 both timestamp values", {28'h0, pad_oe[9:8], pad_out[9:8]}, 32'hD);
        wr(3'd2, 32'h200); ts_val = 2'b10; #1;
        chk("R7 open-drain on timestamp", {28'h0, pad_oe[9:8], pad_out[9:8]}, 32'h4);
        wr(3'd2, 32'h0); ts_oe = 2'b00; ts_val = 2'b00;
        wr(3'd0, 32'h100); wr(3'd1, 32'h100);
        chk("R7 direction alone drives pin8", {28'h0, pad_oe[9:8], pad_out[9:8]}, 32'h5);
        wr(3'd1, 32'h0); wr(3'd0, 32'h0);
    endtask

    task automatic t_led();
        led_val = 8'h05;
        wr(3'd6, 32'h0F);
        chk("R8 LED pins driven", {24'h0, pad_oe[7:0]}, 32'h0F);
        chk("R8 LED values", {28'h0, pad_out[3:0]}, 32'h5);
        wr(3'd0, 32'hF0); wr(3'd1, 32'hFF);
        chk("R8 LED and GPIO outputs", {24'h0, pad_out[7:0]}, 32'hF5);
        wr(3'd6, 32'h0); wr(3'd1, 32'h0); wr(3'd0, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        @(negedge clk); pad_in = 12'hFFF;
        wr(3'd3, 32'h0); wr(3'd4, 32'h0); settle(); wr(3'd5, 32'hFFF); settle();
        rd(3'd5, v); chk("R9 no status while inactive", v, 32'h0);
        chk("R11 irq low", {31'h0, irq}, 32'h0);
        wr(3'd4, 32'h001); pad_in = 12'hFFC; settle();
        rd(3'd5, v); chk("R9 low-active sets only enabled pin", v, 32'h001);
        chk("R11 irq high", {31'h0, irq}, 32'h1);
        wr(3'd4, 32'h0);
        rd(3'd5, v); chk("R11 status sticky after disable", v, 32'h001);
        chk("R11 irq drops with enable", {31'h0, irq}, 32'h0);
        wr(3'd3, 32'h004); wr(3'd4, 32'h004); settle();
        rd(3'd5, v); chk("R9 high-active polarity", v, 32'h005);
        chk("R11 irq from pin2", {31'h0, irq}, 32'h1);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(3'd5, 32'h001);
        rd(3'd5, v); chk("R10 write one clears", v, 32'h004);
        wr(3'd5, 32'h004);
        rd(3'd5, v); chk("R10 still-active bit sets again", v, 32'h004);
        @(negedge clk); pad_in = 12'hFF8; settle();
        wr(3'd5, 32'h0);
        rd(3'd5, v); chk("R10 write zero keeps bit", v, 32'h004);
        wr(3'd5, 32'h004);
        rd(3'd5, v); chk("R10 cleared once inactive", v, 32'h0);
        chk("R11 irq low after clear", {31'h0, irq}, 32'h0);
        wr(3'd4, 32'h0); wr(3'd3, 32'h0);
    endtask

    task automatic t_led_irq();
        logic [31:0] v;
        wr(3'd6, 32'h08);
        @(negedge clk); pad_in = 12'hFF0;
        wr(3'd4, 32'h008); settle();
        rd(3'd5, v); chk("R12 LED pin sets no status", v, 32'h0);
        chk("R12 LED pin raises no irq", {31'h0, irq}, 32'h0);
        wr(3'd6, 32'h0); settle();
        rd(3'd5, v); chk("R12 same pin as GPIO sets status", v, 32'h008);
        chk("R12 same pin as GPIO raises irq", {31'h0, irq}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        strap_led = 8'h00;
        @(negedge clk);
        t_reset();
        t_pushpull();
        t_opendrain();
        t_input();
        t_ts();
        t_led();
        t_irq();
        t_w1c();
        t_led_irq();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule